// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in a transmit byte stream. It takes one outgoing frame at a time, computes a 16-bit ones'-complement checksum over a chosen tail region of it and writes the complemented result back into the frame at a chosen position. Each frame brings its own settings, sampled with its first byte: an enable, a pair of 16-bit offsets packed in one 32-bit word, and a 16-bit seed that the sum starts from.

The checksum position may lie anywhere, including behind the summed bytes, for example in the last two bytes of the frame. The whole frame is therefore held in an internal buffer. Output begins only after the last input byte has been taken. One frame occupies the block at a time, so frames leave in the order they arrived. Both sides use a valid/ready byte stream with an end-of-frame marker.

Top module: `csum_tx_insert`

## Requirements
- R1: With the frame enable (`cfg_en`) clear, every output byte equals the input byte at the same position.
- R2: `cfg_en`, `cfg_offs` and `cfg_seed` are sampled only with the first byte of a frame. Bits 31:16 of `cfg_offs` give the start offset and bits 15:0 give the insert offset, both counted in bytes from 0 at the first frame byte. Changes later in the frame have no effect.
- R3: The sum starts at the seed and adds big-endian 16-bit words taken from the start offset to the frame end. The byte at the start offset is a high byte. An odd last byte is paired with a zero low byte. Carries out of bit 15 wrap back into bit 0.
- R4: When enabled, the output byte at the insert offset carries bits 15:8 of the complemented sum, and the byte after it carries bits 7:0. Those two positions count as zero in the sum.
- R5: An insert position at or beyond the frame length is not written. If only the first of the two positions lies inside the frame, only that byte is replaced. A start offset at or past the frame end gives the complemented seed.
- R6: The output frame has the input frame's length and `out_last` on its final byte. No output byte is valid before the last input byte has been accepted.
- R7: `in_ready` is low from the acceptance of a frame's last byte until its last output byte has been transferred.
- R8: While `out_valid` is high and `out_ready` low, `out_valid`, `out_data` and `out_last` hold their values.
- R9: With seed 0, the insert offset at or after the start offset, an even distance between them and both insert bytes inside the frame, the same sum taken over the output frame from the start offset gives 0xFFFF.
- R10: After reset `out_valid` is low and `in_ready` is high.
- R11: A frame holds 1 to DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| cfg_en | input | 1 | Checksum enable for the frame |
| cfg_offs | input | 32 | Start offset [31:16], insert offset [15:0] |
| cfg_seed | input | 16 | Initial sum value |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last of its frame |

## Verification
The bench sweeps frame lengths, start offsets, insert offsets and seeds, and stalls both sides irregularly.

It targets word alignment from an odd start offset, where a design pairing bytes by absolute position would swap the halves of the sum. It targets odd frame lengths, where a missing zero pad would shift the last byte. It uses all-0xFF data, where a lost end-around carry would leave the sum one short.

Insert offsets at the last byte and past the end check that nothing is written outside the frame. Settings changed after the first byte check that a block re-sampling them would patch the wrong bytes. The receiver-side sum of 0xFFFF confirms that the inserted bytes were treated as zero while summing.

// File: rtl/csum_pkg.sv
package csum_pkg;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;

  // 16-bit ones'-complement addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

endpackage

// File: rtl/csum_frame_ram.sv
module csum_frame_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/csum_accum.sv
module csum_accum
  import csum_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        beat,
  input  logic        first,
  input  logic [15:0] idx,
  input  logic [15:0] seed_in,
  input  logic [15:0] start_in,
  input  logic [15:0] ins_in,
  input  logic [7:0]  data,
  output logic [15:0] sum
);

  logic [16:0] idx_x, ins_x;
  logic        in_region, at_ins;
  logic [15:0] rel, word, base;

  always_comb begin
    idx_x     = {1'b0, idx};
    ins_x     = {1'b0, ins_in};
    in_region = (idx >= start_in);
    at_ins    = (idx_x == ins_x) || (idx_x == ins_x + 17'd1);
    rel       = idx - start_in;
    if (at_ins)      word = 16'h0000;
    else if (rel[0]) word = {8'h00, data};
    else             word = {data, 8'h00};
    base = first ? seed_in : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum <= 16'h0000;
    end else if (beat) begin
      sum <= in_region ? oc_add(base, word) : base;
    end
  end

endmodule

// File: rtl/csum_drain.sv
module csum_drain #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [15:0]   len,
  input  logic          patch_en,
  input  logic [15:0]   ins,
  input  logic [15:0]   csum,
  input  logic [7:0]    rd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          done
);

  logic [15:0] rd_ptr, q_idx;
  logic        q_valid, ld_out, fetch;
  logic [16:0] q_x, ins_x;
  logic [7:0]  patched;

  always_comb begin
    ld_out  = q_valid && (!out_valid || out_ready);
    fetch   = active && (rd_ptr < len) && (!q_valid || ld_out);
    rd_en   = fetch;
    rd_addr = rd_ptr[AW-1:0];
    q_x     = {1'b0, q_idx};
    ins_x   = {1'b0, ins};
    if (patch_en && q_x == ins_x)              patched = csum[15:8];
    else if (patch_en && q_x == ins_x + 17'd1) patched = csum[7:0];
    else                                       patched = rd_data;
    done = out_valid && out_ready && out_last;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      rd_ptr  <= 16'd0;
      q_idx   <= 16'd0;
      q_valid <= 1'b0;
    end else begin
      if (fetch) begin
        rd_ptr <= rd_ptr + 16'd1;
        q_idx  <= rd_ptr;
      end
      if (fetch)       q_valid <= 1'b1;
      else if (ld_out) q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else if (ld_out) begin
      out_valid <= 1'b1;
      out_data  <= patched;
      out_last  <= (q_idx == len - 16'd1);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/csum_tx_insert.sv
module csum_tx_insert
  import csum_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        cfg_en,
  input  logic [31:0] cfg_offs,
  input  logic [15:0] cfg_seed,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);

  localparam int AW = $clog2(DEPTH);

  phase_t      phase;
  logic [15:0] idx, len_q, start_q, ins_q;
  logic        en_q;
  logic        beat, first, drain_done;
  logic [15:0] eff_start, eff_ins, sum;
  logic        rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]  rd_data;

  assign in_ready  = (phase == PH_FILL);
  assign beat      = in_valid && in_ready;
  assign first     = (idx == 16'd0);
  assign eff_start = first ? cfg_offs[31:16] : start_q;
  assign eff_ins   = first ? cfg_offs[15:0]  : ins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_FILL;
      idx     <= 16'd0;
      len_q   <= 16'd1;
      start_q <= 16'd0;
      ins_q   <= 16'd0;
      en_q    <= 1'b0;
    end else begin
      case (phase)
        PH_FILL: if (beat) begin
          if (first) begin
            en_q    <= cfg_en;
            start_q <= cfg_offs[31:16];
            ins_q   <= cfg_offs[15:0];
          end
          if (in_last) begin
            len_q <= idx + 16'd1;
            idx   <= 16'd0;
            phase <= PH_DRAIN;
          end else begin
            idx <= idx + 16'd1;
          end
        end
        PH_DRAIN: if (drain_done) phase <= PH_FILL;
        default: phase <= PH_FILL;
      endcase
    end
  end

  csum_accum u_accum (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .first    (first),
    .idx      (idx),
    .seed_in  (cfg_seed),
    .start_in (eff_start),
    .ins_in   (eff_ins),
    .data     (in_data),
    .sum      (sum)
  );

  csum_frame_ram #(.DW(8), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (beat),
    .waddr (idx[AW-1:0]),
    .wdata (in_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  csum_drain #(.AW(AW)) u_drain (
    .clk       (clk),
    .rst       (rst),
    .active    (phase == PH_DRAIN),
    .len       (len_q),
    .patch_en  (en_q),
    .ins       (ins_q),
    .csum      (~sum),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .done      (drain_done)
  );

endmodule

// File: rtl/csum_tx_insert_chk.sv
module csum_tx_insert_chk #(
  parameter int DEPTH = 2048
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);

  logic [16:0] in_cnt, out_cnt, last_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt   <= 17'd0;
      out_cnt  <= 17'd0;
      last_len <= 17'd0;
    end else begin
      if (in_valid && in_ready) begin
        if (in_last) begin
          in_cnt   <= 17'd0;
          last_len <= in_cnt + 17'd1;
        end else begin
          in_cnt <= in_cnt + 17'd1;
        end
      end
      if (out_valid && out_ready) begin
        out_cnt <= out_last ? 17'd0 : out_cnt + 17'd1;
      end
    end
  end

  p_frame_fits_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (in_cnt < 17'(DEPTH)));

  p_len_match_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> (out_cnt + 17'd1 == last_len));

  p_single_buffer_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind csum_tx_insert csum_tx_insert_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tb_csum_tx_insert.sv
module tb_csum_tx_insert;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_last;
  logic [7:0]  in_data;
  logic        cfg_en;
  logic [31:0] cfg_offs;
  logic [15:0] cfg_seed;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0] fb  [0:127];
  logic [7:0] exb [0:127];
  logic [7:0] ob  [0:127];

  always #5 clk = ~clk;

  csum_tx_insert #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .cfg_en(cfg_en), .cfg_offs(cfg_offs), .cfg_seed(cfg_seed),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int fold16(input int s);
    int v = s;
    while ((v >>> 16) != 0) v = (v & 16'hFFFF) + (v >>> 16);
    return v;
  endfunction

  task automatic run_frame(input int len, input bit en, input int st, input int ins,
                           input int seed, input int pat);
    int s, cs, k, n, t, r;
    bit early, rdy_err, hold_err, got_last, stall, seen_in_rdy;
    logic [7:0] sd, hi, lo;
    logic sl, v, l;
    logic [7:0] d;
    for (int i = 0; i < len; i++)
      fb[i] = (pat == 1) ? 8'hFF : 8'((i * 37 + len * 5 + st * 3 + 8'hA5) & 8'hFF);
    // expected checksum: word-pair model, folded at the end
    s = seed;
    for (int i = st; i < len; i += 2) begin
      hi = (i == ins || i == ins + 1) ? 8'h00 : fb[i];
      lo = (i + 1 >= len) ? 8'h00 : ((i + 1 == ins || i + 1 == ins + 1) ? 8'h00 : fb[i+1]);
      s += {hi, lo};
    end
    cs = (~fold16(s)) & 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      exb[i] = fb[i];
      if (en && i == ins)     exb[i] = cs[15:8];
      if (en && i == ins + 1) exb[i] = cs[7:0];
    end
    // drive the input frame; settings change after the first byte (R2)
    k = 0; early = 0;
    while (k < len) begin
      @(negedge clk);
      in_valid = (($urandom % 4) != 0);
      in_data  = fb[k];
      in_last  = (k == len - 1);
      if (k == 0) begin
        cfg_en = en; cfg_offs = {16'(st), 16'(ins)}; cfg_seed = 16'(seed);
      end else begin
        cfg_en = ~en; cfg_offs = ~{16'(st), 16'(ins)}; cfg_seed = ~16'(seed);
      end
      if (out_valid) early = 1;
      seen_in_rdy = in_ready;
      @(posedge clk);
      if (in_valid && seen_in_rdy) k++;
    end
    @(negedge clk);
    in_valid = 0;
    chk(!early, "R6 no output before last input", early, 0);
    // collect the output frame
    n = 0; t = 0; got_last = 0; stall = 0; rdy_err = 0; hold_err = 0; sd = 0; sl = 0;
    while (!got_last && t < 4000) begin
      if (t != 0) @(negedge clk);
      t++;
      if (in_ready) rdy_err = 1;
      if (stall && (!out_valid || out_data !== sd || out_last !== sl)) hold_err = 1;
      out_ready = (($urandom % 3) != 0);
      v = out_valid; d = out_data; l = out_last;
      @(posedge clk);
      if (v && out_ready) begin
        if (n < 128) begin
          chk(d === exb[n], en ? "R4 R3 output byte" : "R1 passthrough byte", d, exb[n]);
          chk(l === (n == len - 1), "R6 last marker", l, (n == len - 1));
          ob[n] = d;
        end
        if (l) got_last = 1;
        n++;
      end
      stall = v && !out_ready;
      sd = d; sl = l;
    end
    @(negedge clk);
    out_ready = 0;
    chk(n == len, "R6 output length", n, len);
    chk(!rdy_err, "R7 in_ready low while draining", rdy_err, 0);
    chk(!hold_err, "R8 output held under stall", hold_err, 0);
    chk(in_ready, "R7 in_ready back after frame", in_ready, 1);
    // receiver-side property
    if (en && seed == 0 && ins >= st && ((ins - st) % 2 == 0) && ins + 1 < len && n == len) begin
      r = 0;
      for (int i = st; i < len; i += 2)
        r += {ob[i], (i + 1 < len) ? ob[i+1] : 8'h00};
      chk(fold16(r) == 16'hFFFF, "R9 receiver sum", fold16(r), 16'hFFFF);
    end
  endtask

  initial begin
    int insl [4];
    rst = 1; in_valid = 0; in_data = 0; in_last = 0; out_ready = 0;
    cfg_en = 0; cfg_offs = 0; cfg_seed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(out_valid == 0, "R10 reset out_valid", out_valid, 0);
    chk(in_ready == 1, "R10 reset in_ready", in_ready, 1);
    // R1: pass-through sweeps
    for (int len = 1; len <= 14; len++) begin
      run_frame(len, 0, 0, 0, 16'h1234, 0);
      run_frame(len, 0, 1, len - 2 < 0 ? 0 : len - 2, 0, 1);
    end
    // R3 R4 R5 R9: offsets, seeds and data patterns
    for (int len = 1; len <= 14; len++)
      for (int st = 0; st < 4; st++) begin
        insl[0] = st;
        insl[1] = (len >= 2) ? len - 2 : 0;
        insl[2] = len - 1;
        insl[3] = len + 2;
        for (int j = 0; j < 4; j++) begin
          run_frame(len, 1, st, insl[j], 0, (len + st + j) % 2);
          run_frame(len, 1, st, insl[j], 16'hFFFF, 1);
          run_frame(len, 1, st, insl[j], 16'h8001, 0);
        end
      end
    // R11 boundary: full-depth frame, checksum in its last two bytes
    run_frame(DEPTH, 1, 14, DEPTH - 2, 0, 0);
    run_frame(DEPTH, 1, 14, DEPTH - 2, 0, 1);
    // R5: start past the end, insert at the far top of the offset range
    run_frame(8, 1, 20, 3, 16'h00F0, 0);
    run_frame(8, 1, 0, 16'hFFFF, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule